// File: doc/BRIEF.md
# Conditional branch resolver with next-PC select

This block sits at the program-counter stage of a small single-cycle 32-bit RISC core. It takes the two source-register values and a compact condition code from the instruction decoder. From these it decides whether a conditional branch holds. It then produces the address of the next instruction: either the sequential address (current PC plus four) or a branch target supplied from outside.

The block is purely combinational. The decoder drives the condition code. Non-branch instructions get an idle code, so the comparison result stays at zero. The decoder also drives a PC-select bit. That bit must be high for the branch result to steer the PC at all. When it is low, the sequential address is always chosen. The target address is computed by an adder elsewhere in the datapath and only routed here.

Top module: `branch_next_pc`

## Requirements
- R1: Condition code 3'b000 (idle) gives a false condition, so `br_taken` is 0 and `pc_next` is `pc_cur`+4 for any operands.
- R2: Code 3'b001 makes the condition true exactly when `opnd_a` equals `opnd_b`.
- R3: Code 3'b010 makes the condition true exactly when `opnd_a` differs from `opnd_b`.
- R4: Code 3'b011 makes the condition true when `opnd_a` < `opnd_b` as two's-complement numbers (0xFFFFFFFF < 0x00000001 holds).
- R5: Code 3'b100 makes the condition true when `opnd_a` >= `opnd_b` as two's-complement numbers.
- R6: Code 3'b101 makes the condition true when `opnd_a` < `opnd_b` as unsigned magnitudes (0xFFFFFFFF < 0x00000001 does not hold).
- R7: Code 3'b110 makes the condition true when `opnd_a` >= `opnd_b` as unsigned magnitudes.
- R8: Code 3'b111 is reserved and behaves like the idle code: the condition is false.
- R9: `br_taken` equals `pc_sel` AND the selected condition.
- R10: When `br_taken` is 1, `pc_next` equals `br_target`. Otherwise it equals `pc_cur`+4.
- R11: When `pc_sel` is 0, `pc_next` is `pc_cur`+4 and `br_taken` is 0, whatever the code and operands.
- R12: The sequential address wraps modulo 2^32 (0xFFFFFFFC gives 0x00000000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| cond_sel | input | 3 | Condition code from the decoder (encodings in R1 to R8) |
| pc_sel | input | 1 | Enables the branch result to steer the PC |
| pc_cur | input | 32 | Address of the current instruction |
| br_target | input | 32 | Externally computed branch target address |
| br_taken | output | 1 | High when the branch redirects the PC |
| pc_next | output | 32 | Address of the next instruction |

## Verification
The assertions check the routing rules on every evaluation of the inputs. These are: idle and reserved codes never take, a low PC-select always yields the sequential address, and a taken branch always yields the target. They also check that equality and the strict less-than tests agree with each other on equal operands. Only the bench scenarios can show the per-code comparison truth against an independent model. Those scenarios include the cases where signed and unsigned ordering disagree and the wrap of the sequential address at the top of the address space.

// File: rtl/branch_next_pc.sv
module branch_next_pc #(
  parameter int XLEN   = 32,
  parameter int SEL_W  = 3,
  parameter int INST_B = 4
) (
  input  logic [XLEN-1:0]  opnd_a,
  input  logic [XLEN-1:0]  opnd_b,
  input  logic [SEL_W-1:0] cond_sel,
  input  logic             pc_sel,
  input  logic [XLEN-1:0]  pc_cur,
  input  logic [XLEN-1:0]  br_target,
  output logic             br_taken,
  output logic [XLEN-1:0]  pc_next
);
  localparam logic [SEL_W-1:0] C_OFF = SEL_W'(0);
  localparam logic [SEL_W-1:0] C_EQ  = SEL_W'(1);
  localparam logic [SEL_W-1:0] C_NE  = SEL_W'(2);
  localparam logic [SEL_W-1:0] C_LT  = SEL_W'(3);
  localparam logic [SEL_W-1:0] C_GE  = SEL_W'(4);
  localparam logic [SEL_W-1:0] C_LTU = SEL_W'(5);
  localparam logic [SEL_W-1:0] C_GEU = SEL_W'(6);

  logic [XLEN:0]   diff;
  logic            same, below_u, below_s, cond_ok;
  logic [XLEN-1:0] pc_seq;

  // one subtractor serves every ordering test
  assign diff    = {1'b0, opnd_a} - {1'b0, opnd_b};
  assign same    = (opnd_a == opnd_b);
  assign below_u = diff[XLEN];
  assign below_s = (opnd_a[XLEN-1] ^ opnd_b[XLEN-1]) ? opnd_a[XLEN-1] : below_u;

  always_comb begin
    unique case (cond_sel)
      C_EQ:    cond_ok = same;
      C_NE:    cond_ok = ~same;
      C_LT:    cond_ok = below_s;
      C_GE:    cond_ok = ~below_s;
      C_LTU:   cond_ok = below_u;
      C_GEU:   cond_ok = ~below_u;
      C_OFF:   cond_ok = 1'b0;
      default: cond_ok = 1'b0;
    endcase
  end

  assign pc_seq   = pc_cur + XLEN'(INST_B);
  assign br_taken = pc_sel & cond_ok;
  assign pc_next  = br_taken ? br_target : pc_seq;
endmodule

// File: rtl/branch_next_pc_chk.sv
module branch_next_pc_chk #(
  parameter int XLEN   = 32,
  parameter int SEL_W  = 3,
  parameter int INST_B = 4
) (
  input logic [XLEN-1:0]  opnd_a,
  input logic [XLEN-1:0]  opnd_b,
  input logic [SEL_W-1:0] cond_sel,
  input logic             pc_sel,
  input logic [XLEN-1:0]  pc_cur,
  input logic [XLEN-1:0]  br_target,
  input logic             br_taken,
  input logic [XLEN-1:0]  pc_next
);
  always_comb begin
    if (cond_sel == SEL_W'(0))
      AST_IDLE_NEVER_TAKES: assert (!br_taken);                              // R1
    if (cond_sel == SEL_W'(7))
      AST_RSVD_NEVER_TAKES: assert (!br_taken);                              // R8
    if (!pc_sel)
      AST_NOSEL_SEQUENTIAL: assert (!br_taken && pc_next == pc_cur + XLEN'(INST_B)); // R11
    if (br_taken)
      AST_TAKEN_USES_TARGET: assert (pc_next == br_target);                  // R10
    if (pc_sel && cond_sel == SEL_W'(2) && opnd_a == opnd_b)
      AST_NE_EQUAL_FALSE: assert (!br_taken);                                // R3
    if (pc_sel && cond_sel == SEL_W'(6) && opnd_a == opnd_b)
      AST_GEU_EQUAL_TRUE: assert (br_taken && pc_next == br_target);         // R7
  end
endmodule

bind branch_next_pc branch_next_pc_chk #(.XLEN(XLEN), .SEL_W(SEL_W), .INST_B(INST_B)) chk_i (.*);

// File: tb/branch_next_pc_tb_top.sv
`timescale 1ns/1ps
module branch_next_pc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] opnd_a, opnd_b, pc_cur, br_target, pc_next;
  logic [2:0]  cond_sel;
  logic        pc_sel, br_taken;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  branch_next_pc dut_i (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .cond_sel(cond_sel), .pc_sel(pc_sel),
    .pc_cur(pc_cur), .br_target(br_target), .br_taken(br_taken), .pc_next(pc_next)
  );

  function automatic bit ref_cond(input int code, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, ua, ub;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
    case (code)
      1: return a == b;
      2: return a != b;
      3: return sa < sb;
      4: return sa >= sb;
      5: return ua < ub;
      6: return ua >= ub;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int code);
    case (code)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4: return "R5"; 5: return "R6"; 6: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic apply_and_check(input int code, input bit sel, input logic [31:0] a,
                                 input logic [31:0] b, input logic [31:0] pc,
                                 input logic [31:0] tgt, input string tag);
    bit exp_t;
    logic [31:0] exp_pc;
    @(negedge clk);
    cond_sel = 3'(code); pc_sel = sel; opnd_a = a; opnd_b = b; pc_cur = pc; br_target = tgt;
    exp_t  = sel & ref_cond(code, a, b);
    exp_pc = exp_t ? tgt : pc + 32'd4;
    @(posedge clk); #1;
    checks++;
    if (br_taken !== exp_t) begin
      errors++;
      $display("FAIL %s/R9 taken code=%0d sel=%0b a=%h b=%h: got %b exp %b",
               tag, code, sel, a, b, br_taken, exp_t);
    end
    checks++;
    if (pc_next !== exp_pc) begin
      errors++;
      $display("FAIL %s/R10 next pc code=%0d sel=%0b a=%h b=%h: got %h exp %h",
               tag, code, sel, a, b, pc_next, exp_pc);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb;
    cond_sel = 3'd0; pc_sel = 1'b0; opnd_a = '0; opnd_b = '0; pc_cur = '0; br_target = 32'h100;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (br_taken !== 1'b0 || pc_next !== 32'd4) begin
      errors++;
      $display("FAIL R1 reset state: got taken=%b pc=%h exp 0/00000004", br_taken, pc_next);
    end

    for (int code = 0; code < 8; code++) begin
      for (int sel = 0; sel < 2; sel++) begin
        // sel=0 rows exercise R11
        apply_and_check(code, sel[0], 32'h1234_5678, 32'h1234_5678, 32'h0000_1000, 32'h0000_2000, req_of(code));
        apply_and_check(code, sel[0], 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_1004, 32'h0000_0F00, req_of(code));
        apply_and_check(code, sel[0], 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_1008, 32'h0000_3000, req_of(code));
        apply_and_check(code, sel[0], 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_100C, 32'h0000_4000, req_of(code));
        apply_and_check(code, sel[0], 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_1010, 32'h0000_5000, req_of(code));
        for (int k = 0; k < 20; k++) begin
          ra = $urandom; rb = (k % 4 == 0) ? ra : $urandom;
          apply_and_check(code, sel[0], ra, rb, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, req_of(code));
        end
      end
    end

    // R12 wrap of the sequential address, branch not taken
    apply_and_check(2, 1'b1, 32'h5, 32'h5, 32'hFFFF_FFFC, 32'h0000_0040, "R12");
    apply_and_check(0, 1'b1, 32'h5, 32'h6, 32'hFFFF_FFFC, 32'h0000_0040, "R12");
    apply_and_check(1, 1'b0, 32'h5, 32'h5, 32'hFFFF_FFFC, 32'h0000_0040, "R12");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule